// File: doc/BRIEF.md
# Latched Interval Timer with Cascadable Second Counter

This block is a 16-bit down-counting interval timer that runs from the processor clock and is programmed through a byte-wide register port. Software writes a low latch byte and then a high latch byte. The high-byte write copies the full latch into the counter and starts it. In free-run mode each timeout reloads the counter from the latch in hardware, so a periodic tick needs no reload code in the interrupt handler. Each timeout sets a flag, and an enable bit routes that flag to an active-low interrupt line.

A second 16-bit counter gives longer intervals or counts external events. It can count processor clocks or timeouts of the first timer. It can also count falling edges on an input pin, which is synchronised into the clock domain first. The first timer's period is the latch value plus two cycles, because the reload itself takes one extra cycle. The second counter reloads on the source tick that finds it at zero, so its period is the latch value plus one tick.

Top module: `tick_timer`

## Requirements
- R1: After reset both counters read 0, all status bits read 0 and irq_n is high.
- R2: Writing address 1 (timer A high byte) loads timer A with {written byte, A low latch}, starts it and clears the A flag. Writing address 0 (A low latch) changes neither the counter nor the flag.
- R3: With control bit 0 set (free-run), after a load with latch n timer A reads n, n-1, ..., 0, then 0xFFFF, then n again. A timeout therefore occurs every n+2 clock cycles, so a latch of 998 gives 1000 cycles.
- R4: Each timer A timeout sets status bit 0 (address 6). A read strobe on address 0 clears it. If a timeout and that read fall in the same cycle, the flag stays set.
- R5: With control bit 0 clear (one-shot), timer A sets its flag once. It then keeps decrementing from 0xFFFF with no reload and sets no further flag until address 1 is written again.
- R6: irq_n is low exactly when a status flag is set and its enable bit is set. The enable bits are in address 5: bit 0 for A and bit 1 for B. Status bit 7 mirrors the active interrupt.
- R7: With control bits [2:1] = 0, timer B (low latch at address 2, high byte at address 3) counts every clock. It reloads on the clock that finds it at 0 and sets status bit 1, giving a period of n+1 cycles. A read strobe on address 2 clears status bit 1.
- R8: With control bits [2:1] = 1, timer B decrements once per timer A timeout.
- R9: With control bits [2:1] = 2, timer B decrements once per falling edge of ext_pulse, three clock edges after the pin falls. Rising edges have no effect.
- R10: Control (address 4, bits [2:0]) and interrupt enable (address 5, bits [1:0]) read back as written, with their unused bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, selected by bus_addr |
| ext_pulse | input | 1 | Asynchronous pulse input for timer B |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach is a timeout and a flag-clearing read in the same clock edge. The bench loads a short latch and counts cycles from the load edge. It then issues the read strobe exactly in the cycle where the counter shows zero, which makes both events land on one edge. The 1000-cycle period is measured from the two cycles in which the counter shows 0xFFFF. The pin-counting path is timed in edges from the cycle in which the bench drops the pin.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_LO   = 3'd0,
    RA_HI   = 3'd1,
    RB_LO   = 3'd2,
    RB_HI   = 3'd3,
    R_CTRL  = 3'd4,
    R_IEN   = 3'd5,
    R_STAT  = 3'd6,
    R_SPARE = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    BSRC_CLK = 2'd0,
    BSRC_AUF = 2'd1,
    BSRC_PIN = 2'd2,
    BSRC_OFF = 2'd3
  } bsrc_e;

  // Cycles between timeouts of the reload-step timer
  function automatic int unsigned reload_step_period(int unsigned latch);
    return latch + 2;
  endfunction

  // Source ticks between timeouts of the direct-reload counter
  function automatic int unsigned direct_period(int unsigned latch);
    return latch + 1;
  endfunction

endpackage

// File: rtl/tick_pulse_sync.sv
module tick_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[LAST-1:0], pin_i};
  end

  // previous synchronised level high, current synchronised level low
  assign fall_o = chain_q[LAST] & ~chain_q[LAST-1];

  a_r9_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core #(
  parameter int CW         = 16,
  parameter int BW         = 8,
  parameter bit EXTRA_STEP = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          free_run_i,
  input  logic          lo_we_i,
  input  logic          hi_we_i,
  input  logic [BW-1:0] wdata_i,
  input  logic          flag_clr_i,
  output logic [CW-1:0] count_o,
  output logic          flag_o,
  output logic          timeout_o
);
  localparam int HW = CW - BW;

  logic [BW-1:0] lat_lo_q;
  logic [HW-1:0] lat_hi_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] latch_w;
  logic [CW-1:0] load_w;
  logic          run_q;
  logic          armed_q;
  logic          wrap_q;
  logic          flag_q;

  assign latch_w   = {lat_hi_q, lat_lo_q};
  assign load_w    = {HW'(wdata_i), lat_lo_q};
  assign timeout_o = run_q & armed_q & tick_i & (cnt_q == '0);
  assign count_o   = cnt_q;
  assign flag_o    = flag_q;

  // latches and interrupt flag; a load beats a timeout, a timeout beats a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_lo_q <= '0;
      lat_hi_q <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (lo_we_i) lat_lo_q <= wdata_i;
      if (hi_we_i) lat_hi_q <= HW'(wdata_i);
      if (hi_we_i)         flag_q <= 1'b0;
      else if (timeout_o)  flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  generate
    if (EXTRA_STEP) begin : g_step
      // underflow to all ones, reload on the following cycle
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q   <= '0;
          run_q   <= 1'b0;
          armed_q <= 1'b0;
          wrap_q  <= 1'b0;
        end else if (hi_we_i) begin
          cnt_q   <= load_w;
          run_q   <= 1'b1;
          armed_q <= 1'b1;
          wrap_q  <= 1'b0;
        end else if (run_q && tick_i) begin
          if (wrap_q) begin
            cnt_q  <= latch_w;
            wrap_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
            if (timeout_o) begin
              wrap_q  <= free_run_i;
              armed_q <= free_run_i;
            end
          end
        end
      end

      a_r3_reload_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_q && !hi_we_i) |=> (cnt_q == $past(latch_w)));

      a_r5_oneshot_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_o && !free_run_i && !hi_we_i) |=> (cnt_q == '1) && !wrap_q && !armed_q);

    end else begin : g_direct
      // reload straight from zero on the source tick
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q   <= '0;
          run_q   <= 1'b0;
          armed_q <= 1'b0;
          wrap_q  <= 1'b0;
        end else if (hi_we_i) begin
          cnt_q   <= load_w;
          run_q   <= 1'b1;
          armed_q <= 1'b1;
          wrap_q  <= 1'b0;
        end else if (run_q && tick_i) begin
          if (timeout_o) begin
            cnt_q   <= free_run_i ? latch_w : cnt_q - 1'b1;
            armed_q <= free_run_i;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end

      a_r7_direct_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_o && free_run_i && !hi_we_i) |=> (cnt_q == $past(latch_w)));

      a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !hi_we_i) |=> $stable(cnt_q));
    end
  endgenerate

  a_r2_load_and_clear: assert property (@(posedge clk) disable iff (!rst_n)
    hi_we_i |=> (cnt_q == $past(load_w)) && !flag_q && run_q);

  a_r4_timeout_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && !hi_we_i) |=> flag_q);

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CW          = 16,
  parameter int BW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [BW-1:0]     bus_wdata,
  output logic [BW-1:0]     bus_rdata,
  input  logic              ext_pulse,
  output logic              irq_n
);
  localparam int NFLAG = 2;

  reg_sel_e         addr_e;
  logic             wr_en, rd_en;
  logic             a_lo_we, a_hi_we, b_lo_we, b_hi_we;
  logic             a_clr, b_clr;
  logic             a_free_q;
  bsrc_e            b_src_q;
  logic [NFLAG-1:0] ien_q;
  logic [CW-1:0]    a_cnt, b_cnt;
  logic             a_flag, b_flag;
  logic             a_timeout, b_timeout;
  logic             b_tick;
  logic             pin_fall;
  logic             irq_act;
  logic [BW-1:0]    stat_w;

  assign addr_e  = reg_sel_e'(bus_addr);
  assign wr_en   = bus_sel & bus_wr;
  assign rd_en   = bus_sel & ~bus_wr;
  assign a_lo_we = wr_en && (addr_e == RA_LO);
  assign a_hi_we = wr_en && (addr_e == RA_HI);
  assign b_lo_we = wr_en && (addr_e == RB_LO);
  assign b_hi_we = wr_en && (addr_e == RB_HI);
  assign a_clr   = rd_en && (addr_e == RA_LO);
  assign b_clr   = rd_en && (addr_e == RB_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_free_q <= 1'b0;
      b_src_q  <= BSRC_CLK;
      ien_q    <= '0;
    end else if (wr_en) begin
      if (addr_e == R_CTRL) begin
        a_free_q <= bus_wdata[0];
        b_src_q  <= bsrc_e'(bus_wdata[2:1]);
      end
      if (addr_e == R_IEN) ien_q <= bus_wdata[NFLAG-1:0];
    end
  end

  tick_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (ext_pulse),
    .fall_o (pin_fall)
  );

  tick_timer_core #(.CW(CW), .BW(BW), .EXTRA_STEP(1'b1)) u_tmr_a (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (1'b1),
    .free_run_i (a_free_q),
    .lo_we_i    (a_lo_we),
    .hi_we_i    (a_hi_we),
    .wdata_i    (bus_wdata),
    .flag_clr_i (a_clr),
    .count_o    (a_cnt),
    .flag_o     (a_flag),
    .timeout_o  (a_timeout)
  );

  always_comb begin
    unique case (b_src_q)
      BSRC_CLK: b_tick = 1'b1;
      BSRC_AUF: b_tick = a_timeout;
      BSRC_PIN: b_tick = pin_fall;
      default:  b_tick = 1'b0;
    endcase
  end

  tick_timer_core #(.CW(CW), .BW(BW), .EXTRA_STEP(1'b0)) u_tmr_b (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (b_tick),
    .free_run_i (1'b1),
    .lo_we_i    (b_lo_we),
    .hi_we_i    (b_hi_we),
    .wdata_i    (bus_wdata),
    .flag_clr_i (b_clr),
    .count_o    (b_cnt),
    .flag_o     (b_flag),
    .timeout_o  (b_timeout)
  );

  assign irq_act = |({b_flag, a_flag} & ien_q);
  assign irq_n   = ~irq_act;

  always_comb begin
    stat_w         = '0;
    stat_w[0]      = a_flag;
    stat_w[1]      = b_flag;
    stat_w[BW-1]   = irq_act;
  end

  always_comb begin
    unique case (addr_e)
      RA_LO:   bus_rdata = a_cnt[BW-1:0];
      RA_HI:   bus_rdata = BW'(a_cnt >> BW);
      RB_LO:   bus_rdata = b_cnt[BW-1:0];
      RB_HI:   bus_rdata = BW'(b_cnt >> BW);
      R_CTRL:  bus_rdata = BW'({b_src_q, a_free_q});
      R_IEN:   bus_rdata = BW'(ien_q);
      R_STAT:  bus_rdata = stat_w;
      default: bus_rdata = '0;
    endcase
  end

  a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (a_flag || b_flag));

  a_r8_b_flag_from_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_flag) |-> $past(b_timeout));

  a_r10_ctrl_written: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_e == R_CTRL) |=> ({b_src_q, a_free_q} == $past(bus_wdata[2:0])));

endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ext_pulse = 1'b1;
  logic       irq_n;

  int checks = 0;
  int errors = 0;

  localparam logic [2:0] A_LO = 3'd0, A_HI = 3'd1, B_LO = 3'd2, B_HI = 3'd3;
  localparam logic [2:0] CTRL = 3'd4, IEN = 3'd5, STAT = 3'd6;

  always #10 clk = ~clk;

  tick_timer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ext_pulse (ext_pulse),
    .irq_n     (irq_n)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic peek(logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic peek16(logic [2:0] lo_addr, output logic [15:0] v);
    logic [7:0] h, l;
    peek(lo_addr + 3'd1, h);
    peek(lo_addr, l);
    v = {h, l};
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // expected timer A value k cycles after a free-run load of n
  function automatic logic [15:0] a_expect(int n, int k);
    int m = k % (n + 2);
    return (m <= n) ? 16'(n - m) : 16'hFFFF;
  endfunction

  task automatic test_reset();
    logic [15:0] v; logic [7:0] s;
    peek16(A_LO, v); check("R1 timer A after reset", v, 16'h0);
    peek16(B_LO, v); check("R1 timer B after reset", v, 16'h0);
    peek(STAT, s);   check("R1 status after reset", s, 8'h00);
    check("R1 irq_n after reset", irq_n, 1'b1);
  endtask

  task automatic test_free_run();
    logic [15:0] v; logic [7:0] s, d;
    wr(CTRL, 8'h01); wr(A_LO, 8'd5); wr(A_HI, 8'd0);
    for (int k = 0; k <= 7; k++) begin
      if (k > 0) step(1);
      peek16(A_LO, v);
      check($sformatf("R3 free-run count k=%0d", k), v, a_expect(5, k));
      if (k == 0) begin peek(STAT, s); check("R2 flag clear after load", s[0], 1'b0); end
      if (k == 5) begin peek(STAT, s); check("R4 no flag before timeout", s[0], 1'b0); end
      if (k == 6) begin peek(STAT, s); check("R4 flag set on timeout", s[0], 1'b1); end
    end
    rd(A_LO, d);                                   // k=7 -> 8
    peek(STAT, s); check("R4 read of low byte clears flag", s[0], 1'b0);
    step(4);                                        // k=12, counter at 0
    rd(A_LO, d); check("R3 counter at zero before timeout", d, 8'h00);
    peek(STAT, s); check("R4 timeout wins over same-cycle clear", s[0], 1'b1);
  endtask

  task automatic test_period_998();
    logic [15:0] v; logic [7:0] s;
    int first = -1, second = -1;
    wr(A_LO, 8'hE6);
    peek(STAT, s); check("R2 low latch write leaves flag", s[0], 1'b1);
    wr(A_HI, 8'h03);
    peek(STAT, s); check("R2 high write clears flag", s[0], 1'b0);
    peek16(A_LO, v); check("R2 high write loads 998", v, 16'd998);
    for (int k = 1; k <= 2000; k++) begin
      step(1);
      peek16(A_LO, v);
      if (v == 16'hFFFF) begin
        if (first < 0) first = k;
        else if (second < 0) second = k;
      end
    end
    check("R3 first timeout cycle", first, 32'd999);
    check("R3 period for latch 998", second - first, 32'd1000);
  endtask

  task automatic test_one_shot();
    logic [15:0] v; logic [7:0] s, d;
    wr(CTRL, 8'h00); wr(A_LO, 8'd3); wr(A_HI, 8'd0);
    step(4);
    peek16(A_LO, v); check("R5 one-shot underflow", v, 16'hFFFF);
    peek(STAT, s);   check("R5 one-shot flag", s[0], 1'b1);
    step(1);
    peek16(A_LO, v); check("R5 one-shot keeps counting", v, 16'hFFFE);
    rd(A_LO, d);
    peek16(A_LO, v); check("R5 one-shot no reload", v, 16'hFFFD);
    step(20);
    peek(STAT, s);   check("R5 one-shot no second flag", s[0], 1'b0);
    peek16(A_LO, v); check("R5 one-shot later count", v, 16'hFFE9);
  endtask

  task automatic test_irq();
    logic [7:0] s, d;
    wr(IEN, 8'h00); wr(A_LO, 8'd1); wr(A_HI, 8'd0);
    step(2);
    peek(STAT, s); check("R6 flag set for irq test", s[0], 1'b1);
    check("R6 irq_n masked", irq_n, 1'b1);
    wr(IEN, 8'h02);
    check("R6 irq_n with other enable", irq_n, 1'b1);
    wr(IEN, 8'h01);
    check("R6 irq_n asserted", irq_n, 1'b0);
    peek(STAT, s); check("R6 status bit7 active", s[7], 1'b1);
    rd(A_LO, d);
    check("R6 irq_n released after clear", irq_n, 1'b1);
    wr(IEN, 8'h00);
  endtask

  task automatic test_b_clock();
    logic [15:0] v; logic [7:0] s, d;
    wr(B_LO, 8'd4); wr(B_HI, 8'd0);
    peek16(B_LO, v); check("R7 B load", v, 16'd4);
    step(4);
    peek16(B_LO, v); check("R7 B at zero", v, 16'd0);
    peek(STAT, s);   check("R7 B no flag yet", s[1], 1'b0);
    step(1);
    peek16(B_LO, v); check("R7 B reload", v, 16'd4);
    peek(STAT, s);   check("R7 B flag set", s[1], 1'b1);
    rd(B_LO, d);
    peek(STAT, s);   check("R7 B flag cleared by read", s[1], 1'b0);
    peek16(B_LO, v); check("R7 B keeps counting", v, 16'd3);
    step(4);
    peek(STAT, s);   check("R7 B second period", s[1], 1'b1);
    wr(IEN, 8'h02);
    check("R6 irq_n from B", irq_n, 1'b0);
    rd(B_LO, d);
    check("R6 irq_n released after B clear", irq_n, 1'b1);
    wr(IEN, 8'h00);
  endtask

  task automatic test_b_chain();
    logic [15:0] v; logic [7:0] s;
    wr(CTRL, 8'h03); wr(B_LO, 8'd1); wr(B_HI, 8'd0);
    wr(A_LO, 8'd2); wr(A_HI, 8'd0);
    step(2);
    peek16(B_LO, v); check("R8 B before first A timeout", v, 16'd1);
    step(1);
    peek16(B_LO, v); check("R8 B after first A timeout", v, 16'd0);
    step(3);
    peek16(B_LO, v); check("R8 B waits for A", v, 16'd0);
    peek(STAT, s);   check("R8 B flag not yet", s[1], 1'b0);
    step(1);
    peek16(B_LO, v); check("R8 B reload on second A timeout", v, 16'd1);
    peek(STAT, s);   check("R8 B flag on chained timeout", s[1], 1'b1);
  endtask

  task automatic test_b_pin();
    logic [15:0] v; logic [7:0] s;
    wr(CTRL, 8'h04); wr(B_LO, 8'd3); wr(B_HI, 8'd0);
    ext_pulse = 1'b0;
    step(2);
    peek16(B_LO, v); check("R9 sync delay", v, 16'd3);
    step(1);
    peek16(B_LO, v); check("R9 falling edge counted", v, 16'd2);
    ext_pulse = 1'b1;
    step(5);
    peek16(B_LO, v); check("R9 rising edge ignored", v, 16'd2);
    for (int i = 1; i <= 3; i++) begin
      ext_pulse = 1'b0; step(4);
      ext_pulse = 1'b1; step(4);
      peek16(B_LO, v);
      check($sformatf("R9 pulse %0d count", i), v, (i == 3) ? 16'd3 : 16'(2 - i));
      peek(STAT, s);
      check($sformatf("R9 pulse %0d flag", i), s[1], (i == 3) ? 1'b1 : 1'b0);
    end
  endtask

  task automatic test_readback();
    logic [7:0] d;
    wr(CTRL, 8'hFF); peek(CTRL, d); check("R10 control readback", d, 8'h07);
    wr(IEN, 8'hFF);  peek(IEN, d);  check("R10 enable readback", d, 8'h03);
    wr(IEN, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    test_reset();
    test_free_run();
    test_period_998();
    test_one_shot();
    test_irq();
    test_b_clock();
    test_b_chain();
    test_b_pin();
    test_readback();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule